// File: doc/BRIEF.md
# Freeze Gate Controller for a Reconfigurable Region

This block sits between the static part of a system and a region whose logic can be swapped at run time. A valid/ready stream headed into the region passes through a small internal buffer. Software drives the block through four 32-bit registers on a simple memory-mapped port.

To isolate the region, software requests a freeze. The block stops taking new transfers and delivers everything already buffered. When the buffer is empty it reports the frozen state and holds the outgoing valid low. While the region is frozen, software can hold it in reset through a dedicated output. It then requests an unfreeze, and traffic resumes.

Requests are evaluated in the cycle the control register is written. A request that does not fit the current state is refused and leaves a sticky mark in an error register. That register clears when a one is written to its bit 0.

Top module: `freeze_gate_ctrl`

## Requirements
- R1: After synchronous reset the block runs: the status word reads 2, control reads 0, the error word reads 0, `region_rst` is low and `s_ready` is high.
- R2: Registers sit at byte offsets 0 (status), 4 (control), 8 (error) and 12 (identity), selected by `csr_addr[3:2]`. A read returns its data on `csr_rdata` in the cycle after `csr_ren`. The identity word always reads 2.
- R3: While running, every accepted input word leaves on `m_data` in order. `s_ready` falls when the buffer holds DEPTH words.
- R4: Writing control value 1 (bit 0) while running starts a freeze. From the next cycle `s_ready` is low, while buffered words still leave. Once the buffer is empty the block is frozen and `m_valid` stays low.
- R5: Status bit 0 means frozen and bit 1 means running. During the drain and wake transitions both bits read 0, and the two bits are never 1 together.
- R6: Writing control value 2 (bit 1) while frozen raises `region_rst` while the block stays frozen. Writing 0 to control lowers it. `region_rst` is never high outside the frozen state.
- R7: Writing control value 4 (bit 2) while frozen leaves `s_ready` low for one cycle. The block then runs again with status 2.
- R8: Refused writes set bits in the error word: bit 0 for more than one of control bits 2:0, bit 1 for a freeze when not running, bit 2 for an unfreeze when not frozen, and bit 3 for a reset request when not frozen. A refused write changes neither the state nor the control readback.
- R9: Error bits are sticky across later writes. A write to offset 8 with bit 0 set clears the whole word. A write there with bit 0 clear has no effect.
- R10: Control reads back the last accepted value in bits 2:0, and all higher bits read 0. A write of 0 is always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wen | input | 1 | Register write strobe |
| csr_ren | input | 1 | Register read strobe |
| csr_addr | input | 4 | Byte address of the register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid the cycle after `csr_ren` |
| s_valid | input | 1 | Incoming word valid |
| s_data | input | DW | Incoming word |
| s_ready | output | 1 | Block accepts the incoming word |
| m_valid | output | 1 | Word toward the region valid |
| m_data | output | DW | Word toward the region |
| m_ready | input | 1 | Region accepts the word |
| region_rst | output | 1 | Reset held on the isolated region |

## Verification
The assertions check several properties on every cycle:
- the frozen state always has an empty buffer and a quiet output;
- the buffer never grows outside the running state;
- the wake state lasts exactly one cycle;
- `region_rst` is confined to the frozen state;
- error bits never vanish without a clear;
- a refused request never moves a stable state.

The bench scenarios are needed to show the order and completeness of drained traffic and the transient all-zero status during a drain. They also cover the full sweep of all eight control values from both stable states, checked against an arithmetic model of legality, error bits and readback.

// File: rtl/frzg_pkg.sv
package frzg_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_FROZEN = 2'd2,
    ST_WAKE   = 2'd3
  } frz_state_t;

  localparam int          CSR_AW     = 4;
  localparam logic [1:0]  W_STATUS   = 2'd0;
  localparam logic [1:0]  W_CTRL     = 2'd1;
  localparam logic [1:0]  W_ERR      = 2'd2;
  localparam logic [1:0]  W_IDENT    = 2'd3;
  localparam logic [31:0] IDENT_WORD = 32'd2;

  localparam logic [2:0]  REQ_FREEZE   = 3'b001;
  localparam logic [2:0]  REQ_RESET    = 3'b010;
  localparam logic [2:0]  REQ_UNFREEZE = 3'b100;

  localparam int ERR_W        = 4;
  localparam int ERR_MULTI    = 0;
  localparam int ERR_FREEZE   = 1;
  localparam int ERR_UNFREEZE = 2;
  localparam int ERR_RESET    = 3;
endpackage

// File: rtl/frzg_fifo.sv
module frzg_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [$clog2(DEPTH):0] CNT_FULL = ($clog2(DEPTH)+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [$clog2(DEPTH):0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_FULL);
  assign count     = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/frzg_fsm.sv
module frzg_fsm
  import frzg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [2:0]       ctrl_wdata,
  input  logic             err_clr,
  input  logic             buf_empty,
  output frz_state_t       state,
  output logic [2:0]       ctrl,
  output logic [ERR_W-1:0] err,
  output logic             region_rst
);
  frz_state_t       state_q, state_d;
  logic [2:0]       ctrl_q, ctrl_d;
  logic [ERR_W-1:0] err_q, err_set;
  logic             rrst_q;

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    err_set = '0;
    case (state_q)
      ST_DRAIN: if (buf_empty) state_d = ST_FROZEN;
      ST_WAKE:  state_d = ST_RUN;
      default:  state_d = state_q;
    endcase
    if (ctrl_we) begin
      if ($countones(ctrl_wdata) > 1) begin
        err_set[ERR_MULTI] = 1'b1;
      end else begin
        case (ctrl_wdata)
          3'b000: ctrl_d = 3'b000;
          REQ_FREEZE: begin
            if (state_q == ST_RUN) begin
              ctrl_d  = ctrl_wdata;
              state_d = ST_DRAIN;
            end else err_set[ERR_FREEZE] = 1'b1;
          end
          REQ_RESET: begin
            if (state_q == ST_FROZEN) ctrl_d = ctrl_wdata;
            else err_set[ERR_RESET] = 1'b1;
          end
          REQ_UNFREEZE: begin
            if (state_q == ST_FROZEN) begin
              ctrl_d  = ctrl_wdata;
              state_d = ST_WAKE;
            end else err_set[ERR_UNFREEZE] = 1'b1;
          end
          default: ctrl_d = ctrl_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      ctrl_q  <= '0;
      err_q   <= '0;
      rrst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      err_q   <= err_clr ? '0 : (err_q | err_set);
      rrst_q  <= ctrl_d[1] && (state_d == ST_FROZEN);
    end
  end

  assign state      = state_q;
  assign ctrl       = ctrl_q;
  assign err        = err_q;
  assign region_rst = rrst_q;

  assert_refused_keeps_state_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && (err_set != '0) && (state_q == ST_RUN || state_q == ST_FROZEN))
      |=> (state_q == $past(state_q)) && (ctrl_q == $past(ctrl_q)));
  assert_reset_only_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    region_rst |-> (state_q == ST_FROZEN));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ((err_q != '0) && !err_clr) |=> (err_q != '0));
  assert_wake_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE) |=> (state_q == ST_RUN));
endmodule

// File: rtl/frzg_csr_rd.sv
module frzg_csr_rd
  import frzg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ren,
  input  logic [1:0]       word,
  input  logic [1:0]       status,
  input  logic [2:0]       ctrl,
  input  logic [ERR_W-1:0] err,
  output logic [31:0]      rdata
);
  logic [31:0] rdata_q, sel;

  always_comb begin
    case (word)
      W_STATUS: sel = {30'd0, status};
      W_CTRL:   sel = {29'd0, ctrl};
      W_ERR:    sel = {{(32-ERR_W){1'b0}}, err};
      default:  sel = IDENT_WORD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata_q <= '0;
    else if (ren) rdata_q <= sel;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/freeze_gate_ctrl.sv
module freeze_gate_ctrl
  import frzg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wen,
  input  logic              csr_ren,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              s_valid,
  input  logic [DW-1:0]     s_data,
  output logic              s_ready,
  output logic              m_valid,
  output logic [DW-1:0]     m_data,
  input  logic              m_ready,
  output logic              region_rst
);
  localparam int CW = $clog2(DEPTH) + 1;

  frz_state_t       state;
  logic [2:0]       ctrl;
  logic [ERR_W-1:0] err;
  logic [1:0]       word, status;
  logic             push, pop, empty, full;
  logic [CW-1:0]    count;
  logic             unused_bits;

  assign word        = csr_addr[3:2];
  assign unused_bits = ^{csr_addr[1:0], csr_wdata[31:3]};

  assign s_ready = (state == ST_RUN) && !full;
  assign m_valid = !empty && (state == ST_RUN || state == ST_DRAIN);
  assign push    = s_valid && s_ready;
  assign pop     = m_valid && m_ready;
  assign status  = {state == ST_RUN, state == ST_FROZEN};

  frzg_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_data(s_data), .pop(pop),
    .head_data(m_data), .empty(empty), .full(full), .count(count)
  );

  frzg_fsm u_fsm (
    .clk(clk), .rst(rst),
    .ctrl_we(csr_wen && word == W_CTRL), .ctrl_wdata(csr_wdata[2:0]),
    .err_clr(csr_wen && word == W_ERR && csr_wdata[0]),
    .buf_empty(empty), .state(state), .ctrl(ctrl), .err(err),
    .region_rst(region_rst)
  );

  frzg_csr_rd u_rd (
    .clk(clk), .rst(rst), .ren(csr_ren), .word(word), .status(status),
    .ctrl(ctrl), .err(err), .rdata(csr_rdata)
  );

  assert_frozen_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FROZEN) |-> (count == '0) && !m_valid);
  assert_no_growth_R4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |=> (count <= $past(count)));
  assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(status) <= 1);
endmodule

// File: tb/test_freeze_gate_ctrl.sv
module test_freeze_gate_ctrl;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 0, rst = 1;
  logic csr_wen = 0, csr_ren = 0;
  logic [3:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic s_valid = 0, s_ready, m_valid, m_ready = 0, region_rst;
  logic [DW-1:0] s_data = 0, m_data;

  int checks = 0, fails = 0;
  int exp_q[$];
  int got_cnt = 0;

  always #5 clk = ~clk;

  freeze_gate_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_freeze_gate_ctrl (
    .clk(clk), .rst(rst), .csr_wen(csr_wen), .csr_ren(csr_ren),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .region_rst(region_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sink monitor, samples 3 ns after the falling edge
  always @(negedge clk) begin
    #3;
    if (!rst && m_valid && m_ready) begin
      got_cnt++;
      if (exp_q.size() == 0) chk("R3 unexpected word", int'(m_data), -1);
      else chk("R3 order", int'(m_data), exp_q.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; s_valid = 0; m_ready = 0; csr_wen = 0; csr_ren = 0;
    repeat (3) @(negedge clk);
    rst = 0; exp_q.delete(); got_cnt = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); csr_wen = 1; csr_addr = 4'(a); csr_wdata = 32'(d);
    @(negedge clk); csr_wen = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); csr_ren = 1; csr_addr = 4'(a);
    @(negedge clk); csr_ren = 0; d = int'(csr_rdata);
  endtask

  task automatic push(input int v);
    @(negedge clk); s_valid = 1; s_data = DW'(v);
    #3;
    while (!s_ready) begin @(negedge clk); #3; end
    @(negedge clk); s_valid = 0; exp_q.push_back(v);
  endtask

  int d;

  initial begin
    do_reset();
    // R1 reset state, R2 map and identity
    rd(0, d);  chk("R1 status", d, 2);
    rd(4, d);  chk("R1 ctrl", d, 0);
    rd(8, d);  chk("R1 err", d, 0);
    rd(12, d); chk("R2 identity", d, 2);
    chk("R1 region_rst", int'(region_rst), 0);
    chk("R1 s_ready", int'(s_ready), 1);

    // R3 fill the buffer with the sink stalled
    for (int i = 0; i < DEPTH; i++) push(8'h10 + i);
    #3; chk("R3 full stops intake", int'(s_ready), 0);
    @(negedge clk); m_ready = 1;
    repeat (DEPTH + 2) @(negedge clk);
    chk("R3 all delivered", got_cnt, DEPTH);
    chk("R3 ready again", int'(s_ready), 1);

    // R4/R5 freeze with words in flight
    m_ready = 0; got_cnt = 0;
    for (int i = 0; i < 3; i++) push(8'hA0 + i);
    wr(4, 1);
    chk("R4 intake closed", int'(s_ready), 0);
    rd(0, d); chk("R5 drain status", d, 0);
    @(negedge clk); m_ready = 1;
    repeat (6) @(negedge clk);
    chk("R4 drained words", got_cnt, 3);
    rd(0, d); chk("R5 frozen status", d, 1);
    s_valid = 1; s_data = 8'hEE;
    repeat (3) @(negedge clk);
    chk("R4 no output frozen", int'(m_valid), 0);
    chk("R4 no intake frozen", int'(s_ready), 0);
    s_valid = 0;
    wr(4, 0);

    // R6 region reset while frozen
    wr(4, 2); @(negedge clk);
    chk("R6 region_rst high", int'(region_rst), 1);
    rd(0, d); chk("R6 still frozen", d, 1);
    rd(4, d); chk("R10 ctrl readback", d, 2);
    wr(4, 0); @(negedge clk);
    chk("R6 region_rst low", int'(region_rst), 0);

    // R7 unfreeze
    wr(4, 4);
    chk("R7 wake cycle", int'(s_ready), 0);
    @(negedge clk);
    chk("R7 running", int'(s_ready), 1);
    rd(0, d); chk("R7 status", d, 2);
    wr(4, 0);
    got_cnt = 0; push(8'h55); repeat (2) @(negedge clk);
    chk("R7 traffic resumes", got_cnt, 1);

    // R9 sticky error and clear
    wr(4, 4);
    rd(8, d); chk("R8 unfreeze while running", d, 4);
    wr(4, 0);
    rd(8, d); chk("R9 sticky", d, 4);
    wr(8, 2);
    rd(8, d); chk("R9 clear needs bit0", d, 4);
    wr(8, 1);
    rd(8, d); chk("R9 cleared", d, 0);

    // R8/R10 sweep of all control values from both stable states
    for (int fz = 0; fz < 2; fz++) begin
      for (int v = 0; v < 8; v++) begin
        int e_err, e_st, e_ctrl, e_rr, ones;
        do_reset();
        if (fz == 1) begin wr(4, 1); repeat (3) @(negedge clk); wr(4, 0); end
        wr(4, v | 32'h100);
        repeat (3) @(negedge clk);
        ones = (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1);
        e_err = 0;
        if (ones > 1) e_err = 1;
        else if (v == 1 && fz == 1) e_err = 2;
        else if (v == 4 && fz == 0) e_err = 4;
        else if (v == 2 && fz == 0) e_err = 8;
        e_ctrl = (e_err == 0) ? v : 0;
        if (e_err != 0) e_st = fz ? 1 : 2;
        else if (v == 1) e_st = 1;
        else if (v == 4) e_st = 2;
        else e_st = fz ? 1 : 2;
        e_rr = (e_ctrl == 2 && e_st == 1) ? 1 : 0;
        rd(8, d); chk("R8 sweep err", d, e_err);
        rd(0, d); chk("R8 sweep status", d, e_st);
        rd(4, d); chk("R10 sweep ctrl", d, e_ctrl);
        chk("R6 sweep region_rst", int'(region_rst), e_rr);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(10 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule